// File: doc/BRIEF.md
# AES-128 Iterative Decryption Core

This block recovers one 128-bit plaintext block from one 128-bit ciphertext block with the AES-128 inverse cipher. One full inverse round is computed per clock cycle, so a block takes ten round cycles after the start strobe is accepted. The key input is not the cipher key but the last key of the forward schedule (round 10). The core asks for the remaining round keys, in falling order from 9 to 0, through a round-index output. An external reverse-running key generator answers it on a round-key input in the same cycle.

Each of the first nine round steps applies the inverse row rotation, the inverse byte substitution, the round-key XOR and the inverse column mix, in that order. The tenth step omits the column mix. The inverse substitution is computed arithmetically as the inverse affine map followed by the multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1, with no stored table.

Top module: `aes128_dec_iter`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, busy and done are 0 and ptext is all zeros.
- R2: A start sampled high while busy is 0 loads ctext XOR last_key as the working state. In the next cycle busy is 1 and key_idx is 9.
- R3: While busy, key_idx falls by exactly 1 each cycle from 9 to 0. The key on round_key in the cycle that shows key_idx = k is used as the round-k key.
- R4: done is high for exactly one cycle, 11 cycles after the cycle in which start was accepted (after ten round cycles). busy is 0 in that cycle.
- R5: ptext changes only in a cycle in which done is high. It then holds until the result of the next accepted block appears.
- R6: A start pulse while busy is 1 is ignored. The block in flight finishes with its own result and its own timing.
- R7: ptext equals the AES-128 inverse cipher of ctext. With cipher key 000102030405060708090a0b0c0d0e0f (last_key 13111d7fe3944a17f307a78b4d2b30c5), ciphertext 69c4e0d86a7b0430d8cdb78070b4c55a gives 00112233445566778899aabbccddeeff.
- R8: Byte i of a 128-bit state is bits [127-8i -: 8], at row i mod 4 and column i div 4. The inverse row step leaves row 0 unchanged and rotates rows 1, 2 and 3 right by 1, 2 and 3 columns.
- R9: Inverse substitution of byte b is the GF(2^8) inverse (0 maps to 0) of the inverse affine map a_i = b_(i+2) ^ b_(i+5) ^ b_(i+7) ^ c_i, where c = 0x05 and indices are taken mod 8. It maps 0x63 to 0x00.
- R10: The inverse column mix multiplies each column (row 0 = top byte) by 0B x^3 + 0D x^2 + 09 x + 0E modulo x^4+1.
- R11: The round step that uses the round-0 key omits the inverse column mix. Every other round step applies it after the key XOR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, accepted only when idle |
| ctext | input | 128 | Ciphertext block, sampled with an accepted start |
| last_key | input | 128 | Round-10 key of the forward schedule, sampled with start |
| round_key | input | 128 | Round key for the index shown on key_idx |
| key_idx | output | 4 | Index of the round key requested this cycle |
| busy | output | 1 | A block is being processed |
| done | output | 1 | One-cycle pulse: ptext has just been updated |
| ptext | output | 128 | Recovered plaintext, held until the next result |

## Verification
Assertions check on every cycle the sequencing properties. These are the load into round index 9, the single downward step of key_idx while busy, the refusal of a start while busy, the single-cycle done that follows the index-0 round, and the rule that ptext moves only with done. The arithmetic can be shown only by the bench's scenarios, which compare against an independent model. That arithmetic covers the row rotation direction, the inverse substitution, the mix coefficients and the missing mix in the last round. The scenarios are the standard vector, a ciphertext equal to the last key (all-zero working state), and a sweep of pseudo-random keys and blocks. The bench builds its model from a forward substitution table it inverts and from a forward key expansion.

// File: rtl/aes_dec_pkg.sv
package aes_dec_pkg;
  localparam int BYTE_W = 8;
  localparam int NROW   = 4;
  localparam int NCOL   = 4;
  localparam int BLK_W  = BYTE_W * NROW * NCOL;
  localparam int NROUND = 10;

  // multiply by x modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_x2(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, p;
    acc = 8'h00;
    p   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = gf_x2(p);
    end
    return acc;
  endfunction

  // a^254 = product of a^(2^i), i = 1..7; 0 stays 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r, p;
    r = 8'h01;
    p = a;
    for (int i = 1; i < 8; i++) begin
      p = gf_mul(p, p);
      r = gf_mul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] inv_affine(input logic [7:0] b);
    logic [7:0] o;
    for (int i = 0; i < 8; i++)
      o[i] = b[(i + 2) % 8] ^ b[(i + 5) % 8] ^ b[(i + 7) % 8];
    return o ^ 8'h05;
  endfunction

  function automatic logic [7:0] inv_sub(input logic [7:0] b);
    return gf_inv(inv_affine(b));
  endfunction
endpackage

// File: rtl/aes_dec_invsbox.sv
module aes_dec_invsbox
  import aes_dec_pkg::*;
(
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout
);
  always_comb dout = inv_sub(din);
endmodule

// File: rtl/aes_dec_invmixcol.sv
module aes_dec_invmixcol
  import aes_dec_pkg::*;
(
  input  logic [NROW*BYTE_W-1:0] col_in,
  output logic [NROW*BYTE_W-1:0] col_out
);
  // coefficient for distance (k - r) mod 4 between input row k and output row r
  localparam logic [7:0] CF [NROW] = '{8'h0e, 8'h0b, 8'h0d, 8'h09};

  for (genvar r = 0; r < NROW; r++) begin : g_row
    always_comb begin
      logic [7:0] acc;
      acc = 8'h00;
      for (int k = 0; k < NROW; k++)
        acc = acc ^ gf_mul(CF[(k - r + NROW) % NROW],
                           col_in[NROW*BYTE_W-1-BYTE_W*k -: BYTE_W]);
      col_out[NROW*BYTE_W-1-BYTE_W*r -: BYTE_W] = acc;
    end
  end
endmodule

// File: rtl/aes_dec_round.sv
module aes_dec_round
  import aes_dec_pkg::*;
(
  input  logic [BLK_W-1:0] state_in,
  input  logic [BLK_W-1:0] rkey,
  input  logic             last,
  output logic [BLK_W-1:0] state_out
);
  localparam int COL_W = NROW * BYTE_W;

  logic [BLK_W-1:0] shifted, subbed, keyed, mixed;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    for (genvar r = 0; r < NROW; r++) begin : g_byte
      // rotate right by r: column c takes byte from column c-r
      localparam int DST = NROW * c + r;
      localparam int SRC = NROW * ((c - r + NCOL) % NCOL) + r;
      assign shifted[BLK_W-1-BYTE_W*DST -: BYTE_W] = state_in[BLK_W-1-BYTE_W*SRC -: BYTE_W];
      aes_dec_invsbox u_sbox (
        .din  (shifted[BLK_W-1-BYTE_W*DST -: BYTE_W]),
        .dout (subbed [BLK_W-1-BYTE_W*DST -: BYTE_W])
      );
    end
    aes_dec_invmixcol u_mix (
      .col_in  (keyed[BLK_W-1-COL_W*c -: COL_W]),
      .col_out (mixed[BLK_W-1-COL_W*c -: COL_W])
    );
  end

  assign keyed     = subbed ^ rkey;
  assign state_out = last ? keyed : mixed;
endmodule

// File: rtl/aes_dec_ctrl.sv
module aes_dec_ctrl
  import aes_dec_pkg::*;
#(
  parameter int NR    = NROUND,
  localparam int IDX_W = $clog2(NR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             load,
  output logic             fin,
  output logic [IDX_W-1:0] key_idx
);
  logic [IDX_W-1:0] cnt;

  assign load    = start & ~busy;
  assign fin     = busy & (cnt == '0);
  assign key_idx = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= IDX_W'(NR - 1);
    end else if (busy) begin
      if (fin) busy <= 1'b0;
      else     cnt  <= cnt - 1'b1;
    end
  end

  AST_LOAD_TOP_ROUND: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy && key_idx == IDX_W'(NR - 1)); // R2
  AST_IDX_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !fin |=> busy && key_idx == $past(key_idx) - 1'b1); // R3
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !fin |=> busy && key_idx == $past(key_idx) - 1'b1); // R6
endmodule

// File: rtl/aes128_dec_iter.sv
module aes128_dec_iter
  import aes_dec_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [127:0] ctext,
  input  logic [127:0] last_key,
  input  logic [127:0] round_key,
  output logic [3:0]   key_idx,
  output logic         busy,
  output logic         done,
  output logic [127:0] ptext
);
  logic             load, fin;
  logic [BLK_W-1:0] state_q, round_out;

  aes_dec_ctrl #(.NR(NROUND)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .load    (load),
    .fin     (fin),
    .key_idx (key_idx)
  );

  aes_dec_round u_round (
    .state_in  (state_q),
    .rkey      (round_key),
    .last      (fin),
    .state_out (round_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= '0;
      ptext   <= '0;
      done    <= 1'b0;
    end else begin
      done <= fin;
      if (load)      state_q <= ctext ^ last_key;
      else if (busy) state_q <= round_out;
      if (fin)       ptext   <= round_out;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_DONE_AFTER_IDX0: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy) && $past(key_idx) == 4'd0); // R4
  AST_PTEXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptext) |-> done); // R5
endmodule

// File: tb/tb_aes128_dec_iter.sv
module tb_aes128_dec_iter;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] ctext = '0, last_key = '0, round_key;
  logic [3:0]   key_idx;
  logic         busy, done;
  logic [127:0] ptext;

  int n_cmp = 0, n_bad = 0;
  logic [7:0]   fsb [256];
  logic [7:0]   isb [256];
  logic [127:0] rk  [11];
  logic [31:0]  seed = 32'h2545f491;

  always #2 clk = ~clk;

  aes128_dec_iter dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ctext(ctext), .last_key(last_key),
    .round_key(round_key), .key_idx(key_idx), .busy(busy), .done(done), .ptext(ptext)
  );

  // reverse key generator model: answers the requested index at once
  always_comb round_key = (key_idx <= 4'd10) ? rk[key_idx] : '0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // shift-and-add multiply, reducing the product at the end
  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [14:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (15'(a) << i);
    for (int i = 14; i >= 8; i--) if (p[i]) p = p ^ (15'h11b << (i - 8));
    return p[7:0];
  endfunction

  task automatic build_tables();
    for (int a = 0; a < 256; a++) begin
      logic [7:0] inv, s;
      inv = 8'h00;
      for (int b = 1; b < 256; b++) if (bmul(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
      for (int i = 0; i < 8; i++)
        s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
      fsb[a] = s ^ 8'h63;
    end
    for (int a = 0; a < 256; a++) isb[fsb[a]] = 8'(a);
  endtask

  task automatic expand(input logic [127:0] key);
    logic [31:0] w [44];
    logic [7:0]  rc;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      logic [31:0] t;
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {fsb[t[23:16]], fsb[t[15:8]], fsb[t[7:0]], fsb[t[31:24]]} ^ {rc, 24'h0};
        rc = bmul(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int j = 0; j < 11; j++) rk[j] = {w[4*j], w[4*j+1], w[4*j+2], w[4*j+3]};
  endtask

  function automatic logic [127:0] ref_dec(input logic [127:0] ct);
    logic [7:0] b [16];
    logic [7:0] t [16];
    logic [127:0] s;
    s = ct ^ rk[10];
    for (int rnd = 9; rnd >= 0; rnd--) begin
      for (int i = 0; i < 16; i++) b[i] = s[127-8*i -: 8];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) t[4*c+r] = isb[b[4*((c+4-r)%4)+r]];
      for (int i = 0; i < 16; i++) t[i] = t[i] ^ rk[rnd][127-8*i -: 8];
      if (rnd != 0)
        for (int c = 0; c < 4; c++) begin
          logic [7:0] a0, a1, a2, a3;
          a0 = t[4*c]; a1 = t[4*c+1]; a2 = t[4*c+2]; a3 = t[4*c+3];
          t[4*c]   = bmul(a0,8'd14) ^ bmul(a1,8'd11) ^ bmul(a2,8'd13) ^ bmul(a3,8'd9);
          t[4*c+1] = bmul(a0,8'd9)  ^ bmul(a1,8'd14) ^ bmul(a2,8'd11) ^ bmul(a3,8'd13);
          t[4*c+2] = bmul(a0,8'd13) ^ bmul(a1,8'd9)  ^ bmul(a2,8'd14) ^ bmul(a3,8'd11);
          t[4*c+3] = bmul(a0,8'd11) ^ bmul(a1,8'd13) ^ bmul(a2,8'd9)  ^ bmul(a3,8'd14);
        end
      for (int i = 0; i < 16; i++) s[127-8*i -: 8] = t[i];
    end
    return s;
  endfunction

  function automatic logic [31:0] nxt();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // one block; intrude_at >= 0 pulses a second start at that round step
  task automatic run_block(input logic [127:0] key, input logic [127:0] ct,
                           input int intrude_at, input logic [127:0] exp_known, input bit use_known);
    logic [127:0] exp, held;
    expand(key);
    exp = use_known ? exp_known : ref_dec(ct);
    @(negedge clk);
    ctext = ct; last_key = rk[10]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", 128'(busy), 128'd1);
    for (int k = 0; k < 10; k++) begin
      if (k > 0) @(negedge clk);
      start = 1'b0;
      chk(busy && key_idx == 4'(9 - k), "R3 key index sequence", 128'(key_idx), 128'(9 - k));
      chk(done == 1'b0, "R4 no early done", 128'(done), 128'd0);
      if (k == intrude_at) begin
        ctext = ~ct; last_key = ~rk[10]; start = 1'b1;
      end
    end
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1 && busy == 1'b0, "R4 done after ten rounds", 128'({busy, done}), 128'b01);
    chk(ptext == exp, "R7 R8 R9 R10 R11 plaintext", ptext, exp);
    if (intrude_at >= 0) chk(ptext == exp, "R6 start while busy ignored", ptext, exp);
    held = ptext;
    ctext = ~ctext;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(done == 1'b0, "R4 done single cycle", 128'(done), 128'd0);
      chk(ptext == held, "R5 plaintext held", ptext, held);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R4 watchdog expired: done=%0b expected 1", done);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    build_tables();
    chk(isb[8'h63] == 8'h00, "R9 table 63->00", 128'(isb[8'h63]), 128'h0);
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && ptext == '0, "R1 state in reset", ptext, 128'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && ptext == '0, "R1 state after reset", ptext, 128'h0);

    expand(128'h000102030405060708090a0b0c0d0e0f);
    chk(rk[10] == 128'h13111d7fe3944a17f307a78b4d2b30c5, "R7 last key of schedule",
        rk[10], 128'h13111d7fe3944a17f307a78b4d2b30c5);
    run_block(128'h000102030405060708090a0b0c0d0e0f, 128'h69c4e0d86a7b0430d8cdb78070b4c55a,
              -1, 128'h00112233445566778899aabbccddeeff, 1'b1);
    // ciphertext equal to the last key: all-zero working state enters round 9
    run_block(128'h000102030405060708090a0b0c0d0e0f, 128'h13111d7fe3944a17f307a78b4d2b30c5,
              -1, '0, 1'b0);
    run_block(128'h000102030405060708090a0b0c0d0e0f, 128'h69c4e0d86a7b0430d8cdb78070b4c55a,
              4, 128'h00112233445566778899aabbccddeeff, 1'b1);
    for (int n = 0; n < 40; n++) begin
      logic [127:0] key, ct;
      key = {nxt(), nxt(), nxt(), nxt()};
      ct  = {nxt(), nxt(), nxt(), nxt()};
      if (n == 0) key = '0;
      if (n == 1) ct  = '1;
      run_block(key, ct, (n % 5 == 2) ? (n % 10) : -1, '0, 1'b0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule